// File: doc/BRIEF.md
# Non-Stalling Instruction Fetch Stage

This block is the front end of an in-order pipeline. Each cycle it presents its program counter to the instruction cache. It forwards the returned word as a bundle only when the cache reports a hit and the translation did not fault. A cache miss or a translation miss never freezes the machine behind it. Instead the stage sends a bubble downstream, carrying the all-zero NOP word with its valid flag low, and advances the program counter by a step of zero. The counter therefore holds until the line arrives. Because the rest of the pipeline keeps moving, a pending trap can still be taken, and stale words are never delivered.

A branch redirect is accepted in the cycle it arrives, whether or not a miss is outstanding. The next lookup goes to the new target, and whatever the cache returned for the old address in that cycle is dropped. The flush downstream and the new lookup therefore overlap instead of adding up. A miss counter raises a timeout flag once a miss has stayed unresolved for a set number of cycles, so that a wedged fetch can be noticed.

Top module: `fetch_nop_inject`

## Requirements
- R1: While and directly after reset, `fe_addr` equals `RESET_PC`, `bnd_valid` is 0, `bnd_insn` is 0 and `miss_tmo` is 0.
- R2: In a cycle with `ic_hit`=1, `tlb_miss`=0 and `redir_valid`=0, the next clock edge produces `bnd_valid`=1, `bnd_pc` equal to the fetch address of that cycle, `bnd_insn` equal to `ic_word`, and advances `fe_addr` by `STEP` (4).
- R3: In a cycle with `ic_hit`=0 and no redirect, the next edge produces a bubble (`bnd_valid`=0, `bnd_insn`=32'h0000_0000) and leaves `fe_addr` unchanged.
- R4: In a cycle with `tlb_miss`=1 and no redirect, the next edge produces a bubble with `bnd_insn`=0 and leaves `fe_addr` unchanged, even when `ic_hit`=1 and `ic_word` is non-zero.
- R5: In a cycle with `redir_valid`=1, the next edge produces a bubble and sets `fe_addr` to `redir_pc`, whatever `ic_hit`, `tlb_miss` and `ic_word` are. A word returned in that cycle is never delivered.
- R6: After any run of miss cycles, the first valid bundle carries the held address as `bnd_pc` and the word returned for it.
- R7: `miss_tmo` becomes 1 after `MISS_LIMIT` (1024) consecutive cycles that each produce a miss bubble (R3 or R4), and not earlier. It stays 1 while the miss lasts and returns to 0 one edge after a hit or a redirect, which restarts the count.
- R8: Consecutive valid bundles with no redirect or miss in between have `bnd_pc` values that differ by exactly `STEP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_addr | output | 32 | Fetch address presented to the instruction cache (current PC) |
| ic_hit | input | 1 | Cache reports the word for `fe_addr` is present this cycle |
| ic_word | input | 32 | Instruction word returned by the cache |
| tlb_miss | input | 1 | Translation of `fe_addr` failed this cycle |
| redir_valid | input | 1 | Branch redirect request |
| redir_pc | input | 32 | Redirect target address |
| bnd_valid | output | 1 | Bundle carries a real instruction (0 for a bubble) |
| bnd_pc | output | 32 | Address of the bundle's instruction |
| bnd_insn | output | 32 | Instruction word, all zero for a bubble |
| miss_tmo | output | 1 | Miss has stayed unresolved for `MISS_LIMIT` cycles |

## Verification
Every bundle field, the new fetch address and the timeout flag are registered. Each is due one rising edge after the cycle whose cache, translation and redirect inputs decide it. The bench drives each cycle's inputs on the falling edge and pushes the expected state into a scoreboard queue. A monitor pops and compares that state one time unit after the following rising edge, so every comparison lands exactly one edge after its stimulus. The timeout is checked in every cycle of a long miss run, so a flag raised one cycle early or late is caught.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int unsigned FE_ADDR_W = 32;
    localparam int unsigned FE_INSN_W = 32;

    typedef logic [FE_ADDR_W-1:0] fe_addr_t;
    typedef logic [FE_INSN_W-1:0] fe_insn_t;

    // Bubble word: all zero
    localparam fe_insn_t FE_NOP = '0;

    typedef struct packed {
        logic     valid;
        fe_addr_t pc;
        fe_insn_t insn;
    } fe_bundle_t;

    // What the stage does with the current cycle
    typedef enum logic [1:0] {
        FE_ADVANCE = 2'd0,  // deliver word, step PC
        FE_HOLD    = 2'd1,  // miss: bubble, zero step
        FE_STEER   = 2'd2   // redirect: bubble, load target
    } fe_action_t;

    function automatic fe_action_t fe_decide(input logic redir,
                                             input logic hit,
                                             input logic xlate_miss);
        if (redir)
            return FE_STEER;
        else if (hit && !xlate_miss)
            return FE_ADVANCE;
        else
            return FE_HOLD;
    endfunction

    function automatic fe_addr_t fe_step_pc(input fe_addr_t pc, input fe_addr_t step);
        return pc + step;
    endfunction

endpackage

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter int unsigned STEP     = 4,
    parameter fe_addr_t    RESET_PC = 32'h0000_1000
) (
    input  logic       clk,
    input  logic       rst,
    input  fe_action_t action,
    input  fe_addr_t   target,
    output fe_addr_t   pc
);
    localparam fe_addr_t STEP_A = fe_addr_t'(STEP);

    fe_addr_t step;
    fe_addr_t pc_next;

    always_comb begin
        step    = (action == FE_ADVANCE) ? STEP_A : '0;
        pc_next = (action == FE_STEER) ? target : fe_step_pc(pc, step);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_PC;
        else
            pc <= pc_next;
    end
endmodule

// File: rtl/fetch_bundle_reg.sv
module fetch_bundle_reg
    import fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fe_action_t action,
    input  fe_addr_t   pc,
    input  fe_insn_t   word,
    output fe_bundle_t bundle
);
    fe_bundle_t nxt;

    always_comb begin
        nxt.pc = pc;
        if (action == FE_ADVANCE) begin
            nxt.valid = 1'b1;
            nxt.insn  = word;
        end else begin
            nxt.valid = 1'b0;
            nxt.insn  = FE_NOP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bundle <= '{valid: 1'b0, pc: '0, insn: FE_NOP};
        else
            bundle <= nxt;
    end
endmodule

// File: rtl/fetch_miss_timer.sv
module fetch_miss_timer
    import fetch_pkg::*;
#(
    parameter int unsigned MISS_LIMIT = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  fe_action_t action,
    output logic       timeout
);
    localparam int unsigned CNT_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(MISS_LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (action == FE_HOLD) begin
            if (cnt != LIMIT_C)
                cnt <= cnt + 1'b1;
        end else
            cnt <= '0;
    end

    assign timeout = (cnt == LIMIT_C);
endmodule

// File: rtl/fetch_nop_inject.sv
module fetch_nop_inject
    import fetch_pkg::*;
#(
    parameter int unsigned STEP       = 4,
    parameter int unsigned MISS_LIMIT = 1024,
    parameter logic [31:0] RESET_PC   = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] fe_addr,
    input  logic        ic_hit,
    input  logic [31:0] ic_word,
    input  logic        tlb_miss,
    input  logic        redir_valid,
    input  logic [31:0] redir_pc,
    output logic        bnd_valid,
    output logic [31:0] bnd_pc,
    output logic [31:0] bnd_insn,
    output logic        miss_tmo
);
    fe_action_t action;
    fe_addr_t   pc;
    fe_bundle_t bundle;

    assign action = fe_decide(redir_valid, ic_hit, tlb_miss);

    fetch_pc_unit #(.STEP(STEP), .RESET_PC(RESET_PC)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .action (action),
        .target (redir_pc),
        .pc     (pc)
    );

    fetch_bundle_reg u_bnd (
        .clk    (clk),
        .rst    (rst),
        .action (action),
        .pc     (pc),
        .word   (ic_word),
        .bundle (bundle)
    );

    fetch_miss_timer #(.MISS_LIMIT(MISS_LIMIT)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .action  (action),
        .timeout (miss_tmo)
    );

    assign fe_addr   = pc;
    assign bnd_valid = bundle.valid;
    assign bnd_pc    = bundle.pc;
    assign bnd_insn  = bundle.insn;
endmodule

// File: rtl/fetch_nop_inject_chk.sv
module fetch_nop_inject_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fe_addr,
    input logic        ic_hit,
    input logic [31:0] ic_word,
    input logic        tlb_miss,
    input logic        redir_valid,
    input logic [31:0] redir_pc,
    input logic        bnd_valid,
    input logic [31:0] bnd_pc,
    input logic [31:0] bnd_insn,
    input logic        miss_tmo
);
    assert_hit_delivers_R2: assert property (@(posedge clk) disable iff (rst)
        (ic_hit && !tlb_miss && !redir_valid) |=>
            (bnd_valid && bnd_pc == $past(fe_addr) && bnd_insn == $past(ic_word)));

    assert_miss_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!ic_hit && !redir_valid) |=>
            (!bnd_valid && bnd_insn == 32'h0 && fe_addr == $past(fe_addr)));

    assert_xlate_fault_bubble_R4: assert property (@(posedge clk) disable iff (rst)
        (tlb_miss && !redir_valid) |=>
            (!bnd_valid && bnd_insn == 32'h0 && fe_addr == $past(fe_addr)));

    assert_redirect_steers_R5: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (!bnd_valid && fe_addr == $past(redir_pc)));

    assert_timeout_only_bubbles_R7: assert property (@(posedge clk) disable iff (rst)
        miss_tmo |-> !bnd_valid);
endmodule

bind fetch_nop_inject fetch_nop_inject_chk u_chk (.*);

// File: tb/sim_fetch_nop_inject.sv
module sim_fetch_nop_inject;
    localparam int          CLK_PERIOD = 10;
    localparam int          STEP       = 4;
    localparam int          LIMIT      = 1024;
    localparam logic [31:0] RST_PC     = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fe_addr;
    logic        ic_hit, tlb_miss, redir_valid;
    logic [31:0] ic_word, redir_pc;
    logic        bnd_valid, miss_tmo;
    logic [31:0] bnd_pc, bnd_insn;

    int n_vec = 0;
    int n_bad = 0;

    // Scoreboard queues
    logic        q_valid[$];
    logic [31:0] q_pc[$];
    logic [31:0] q_insn[$];
    logic [31:0] q_addr[$];
    logic        q_tmo[$];
    string       q_tag[$];

    // Reference model state
    logic [31:0] m_pc;
    int          m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_nop_inject #(.STEP(STEP), .MISS_LIMIT(LIMIT), .RESET_PC(RST_PC)) u0 (
        .clk(clk), .rst(rst), .fe_addr(fe_addr), .ic_hit(ic_hit), .ic_word(ic_word),
        .tlb_miss(tlb_miss), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .bnd_valid(bnd_valid), .bnd_pc(bnd_pc), .bnd_insn(bnd_insn), .miss_tmo(miss_tmo)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return 32'hA55A_0000 ^ a ^ 32'h0000_0F01;
    endfunction

    task automatic cyc(input logic hit, input logic tf, input logic rd,
                       input logic [31:0] tgt, input logic [31:0] data, input string tag);
        logic        ev;
        logic [31:0] ei;
        logic [31:0] ep;
        @(negedge clk);
        ic_hit = hit; tlb_miss = tf; redir_valid = rd; redir_pc = tgt; ic_word = data;
        ep = m_pc;
        if (rd) begin
            ev = 1'b0; ei = 32'h0; m_pc = tgt; m_cnt = 0;
        end else if (hit && !tf) begin
            ev = 1'b1; ei = data; m_pc = m_pc + STEP; m_cnt = 0;
        end else begin
            ev = 1'b0; ei = 32'h0;
            if (m_cnt < LIMIT) m_cnt++;
        end
        q_valid.push_back(ev); q_pc.push_back(ep); q_insn.push_back(ei);
        q_addr.push_back(m_pc); q_tmo.push_back(m_cnt >= LIMIT); q_tag.push_back(tag);
    endtask

    // Hit at the current model PC with its own word
    task automatic hit_here(input string tag);
        cyc(1'b1, 1'b0, 1'b0, 32'h0, word_of(m_pc), tag);
    endtask

    // Monitor: compares one edge after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_valid.size() > 0) begin
                logic        ev, et;
                logic [31:0] ep, ei, ea;
                string       tg;
                ev = q_valid.pop_front(); ep = q_pc.pop_front(); ei = q_insn.pop_front();
                ea = q_addr.pop_front(); et = q_tmo.pop_front(); tg = q_tag.pop_front();
                n_vec++;
                if (bnd_valid !== ev || bnd_insn !== ei || fe_addr !== ea || miss_tmo !== et ||
                    (ev && bnd_pc !== ep)) begin
                    n_bad++;
                    $display("FAIL %s: valid=%0b/%0b pc=%h/%h insn=%h/%h addr=%h/%h tmo=%0b/%0b (actual/expected)",
                             tg, bnd_valid, ev, bnd_pc, ep, bnd_insn, ei, fe_addr, ea, miss_tmo, et);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; ic_hit = 1'b0; tlb_miss = 1'b0; redir_valid = 1'b0;
        redir_pc = '0; ic_word = '0;
        m_pc = RST_PC; m_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (fe_addr !== RST_PC || bnd_valid !== 1'b0 || bnd_insn !== 32'h0 || miss_tmo !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: addr=%h valid=%0b insn=%h tmo=%0b expected addr=%h valid=0 insn=0 tmo=0",
                     fe_addr, bnd_valid, bnd_insn, miss_tmo, RST_PC);
        end
        rst = 1'b0;

        // R2 / R8: straight-line hits
        for (int i = 0; i < 5; i++) hit_here("R2_R8 hit stream");

        // R3 then R6: cache miss run, then resume at held PC
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 32'h0, 32'hDEAD_BEEF, "R3 cache miss");
        hit_here("R6 resume after miss");
        hit_here("R8 step after resume");

        // R4: translation miss with a hit and live data
        cyc(1'b1, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFFF, "R4 xlate miss with hit");
        cyc(1'b0, 1'b1, 1'b0, 32'h0, 32'h1234_5678, "R4 xlate miss with cache miss");
        hit_here("R6 resume after xlate miss");

        // R5: redirect during miss, with a hit, with a translation fault
        cyc(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R3 miss before redirect");
        cyc(1'b0, 1'b0, 1'b1, 32'h0000_8000, 32'h0, "R5 redirect during miss");
        hit_here("R5 fetch at target");
        cyc(1'b1, 1'b0, 1'b1, 32'h0000_9F00, 32'hCAFE_F00D, "R5 redirect drops hit word");
        cyc(1'b1, 1'b1, 1'b1, 32'h0000_0040, 32'hBAD0_BAD0, "R5 redirect over xlate miss");
        hit_here("R5 fetch at second target");
        hit_here("R8 step after redirect");

        // R7: full miss run reaching the limit
        for (int i = 0; i < LIMIT + 3; i++) cyc(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R7 timeout run");
        hit_here("R7 timeout clears on hit");
        // R7: just under the limit, then redirect restarts the count
        for (int i = 0; i < LIMIT - 1; i++) cyc(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R7 below limit");
        cyc(1'b0, 1'b0, 1'b1, 32'h0000_2000, 32'h0, "R7 redirect restarts count");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 32'h0, 32'h0, "R7 count restarted");
        hit_here("R6 resume at redirect target");

        @(negedge clk);
        ic_hit = 1'b0; tlb_miss = 1'b0; redir_valid = 1'b0;
        @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule